// File: doc/BRIEF.md
# Word-Packing Receive Buffer with Level and Idle Interrupts

This block sits behind a serial receiver and collects the characters it delivers. Each character arrives with a flag from the receiver's parity and framing check. Characters that fail the check are dropped. Good characters are gathered four at a time into a 32-bit word, and complete words enter a small word FIFO. The processor then reads whole 32-bit words and so uses the full bus width.

Two interrupt flags keep the interrupt rate low. A level flag is raised while the FIFO holds more words than a programmable threshold. An idle flag covers the case where data waits below that threshold. It is driven by a timer that counts baud-enable ticks while data is held and no character or read has occurred. When the timer expires, any partly filled word is moved into the FIFO with its unused upper lanes zeroed. The number of valid characters in that word is kept on a length output, so the processor knows how much of the last word to use.

A good character that arrives while the FIFO is full is discarded, and this sets a sticky overrun flag that only reset clears.

Top module: `rx_word_buffer`

## Requirements
- R1: A character presented with `byteGood` low is not stored. It leaves the word count, the packing state and the idle timer unchanged.
- R2: Good characters fill lanes from the least significant end. The first character goes to bits 7:0 and the fourth to bits 31:24. The fourth character writes the word into the FIFO, and `wordCount` shows the new count one clock after that character.
- R3: `rdData` shows the oldest stored word. A cycle with `rdEn` high and a non-empty FIFO removes that word. `rdEn` on an empty FIFO has no effect.
- R4: While `threshold` is held constant, `thrIrq` is high exactly when `wordCount` is greater than `threshold`. It changes in the same cycle as `wordCount`.
- R5: The idle timer advances only on `baudTick` cycles, and only while data is held in the FIFO or in the partial word, the count is not above the threshold, and `toIrq` is low. `toIrq` rises on the `TIMEOUT_TICKS`-th such tick, and not before.
- R6: An accepted good character or a word read resets the idle timer to zero.
- R7: When the timer expires with 1 to 3 characters in the partial word, that word enters the FIFO with its unused upper lanes zero, and `lastLen` takes the character count. When it expires with no partial word, `lastLen` takes 4.
- R8: `toIrq` stays high until a read empties the FIFO, and then it goes low.
- R9: A good character that arrives while `wordCount` equals `FIFO_DEPTH` is discarded and sets `overrun`. `overrun` stays high until reset, and the discarded character never appears in a later word.
- R10: After reset, `wordCount` is 0, `fifoEmpty` is 1, both interrupt flags are 0, `overrun` is 0 and `lastLen` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received character is present this cycle |
| byteData | input | 8 | Received character |
| byteGood | input | 1 | Character passed the parity and frame check |
| baudTick | input | 1 | Baud-rate enable pulse that clocks the idle timer |
| threshold | input | $clog2(FIFO_DEPTH+1) | Word count above which `thrIrq` is raised |
| rdEn | input | 1 | Remove the oldest word |
| rdData | output | 32 | Oldest stored word |
| wordCount | output | $clog2(FIFO_DEPTH+1) | Number of words in the FIFO |
| fifoEmpty | output | 1 | FIFO holds no word |
| lastLen | output | 3 | Valid characters (1 to 4) in the word moved in by the last expiry |
| thrIrq | output | 1 | Level interrupt: count above threshold |
| toIrq | output | 1 | Idle timeout interrupt |
| overrun | output | 1 | Sticky flag: a character was lost to a full FIFO |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `TIMEOUT_TICKS` = 6. With these values, every threshold from 0 to 3 can be swept against every fill level from 0 to 4. They also make a full FIFO, and so the overrun path, reachable in sixteen characters. The short timer allows every mix of zero or one full word with zero to three leftover characters to be run through expiry and drained. Each run checks the exact tick on which `toIrq` rises and the value of `lastLen`.

// File: rtl/rx_word_buffer_pkg.sv
package rx_word_buffer_pkg;
  // strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic takeByte;   // place the incoming character into the next lane
    logic flushPart;  // move the partial word into the FIFO
    logic popWord;    // remove the oldest word
  } dpStrobe_t;
endpackage

// File: rtl/rx_word_dp.sv
module rx_word_dp
  import rx_word_buffer_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CW = $clog2(FIFO_DEPTH + 1),
  parameter int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [7:0]    byteIn,
  output logic [31:0]   rdData,
  output logic [CW-1:0] wordCount,
  output logic [1:0]    packCnt,
  output logic          fifoFull
);
  logic [31:0] packReg;
  logic [31:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic wordDone, pushNow, popNow;
  logic [31:0] pushWord;

  assign wordDone = strobe.takeByte && (packCnt == 2'd3);
  assign pushNow  = wordDone || (strobe.flushPart && (packCnt != 2'd0));
  assign pushWord = wordDone ? {byteIn, packReg[23:0]} : packReg;
  assign popNow   = strobe.popWord && (wordCount != '0);
  assign fifoFull = (wordCount == CW'(FIFO_DEPTH));
  assign rdData   = mem[rdPtr];

  // packing register: lanes fill upward, cleared whenever its word leaves
  always_ff @(posedge clk) begin
    if (!rstN) begin
      packReg <= '0;
      packCnt <= 2'd0;
    end else if (strobe.takeByte) begin
      if (wordDone) begin
        packReg <= '0;
      end else begin
        packReg[{packCnt, 3'b000} +: 8] <= byteIn;
      end
      packCnt <= packCnt + 2'd1;
    end else if (strobe.flushPart) begin
      packReg <= '0;
      packCnt <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (pushNow) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      wordCount <= '0;
    end else begin
      if (pushNow) wrPtr <= (wrPtr == AW'(FIFO_DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (popNow)  rdPtr <= (rdPtr == AW'(FIFO_DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({pushNow, popNow})
        2'b10:   wordCount <= wordCount + CW'(1);
        2'b01:   wordCount <= wordCount - CW'(1);
        default: wordCount <= wordCount;
      endcase
    end
  end

  // R9: control never lets a word in while the FIFO is full
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushNow |-> (wordCount < CW'(FIFO_DEPTH)));

  // R1: without a take or flush the packing state holds
  p_pack_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.takeByte && !strobe.flushPart) |=> $stable(packCnt));

  // R7: a flush leaves the partial word empty
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushPart && !strobe.takeByte) |=> (packCnt == 2'd0));

  // R3: count stays within the storage
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordCount <= CW'(FIFO_DEPTH));
endmodule

// File: rtl/rx_word_ctrl.sv
module rx_word_ctrl
  import rx_word_buffer_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TIMEOUT_TICKS = 64,
  parameter int CW = $clog2(FIFO_DEPTH + 1),
  parameter int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic          byteGood,
  input  logic          baudTick,
  input  logic [CW-1:0] threshold,
  input  logic          rdEn,
  input  logic [CW-1:0] wordCount,
  input  logic [1:0]    packCnt,
  input  logic          fifoFull,
  output dpStrobe_t     strobe,
  output logic          thrIrq,
  output logic          toIrq,
  output logic          overrun,
  output logic [2:0]    lastLen
);
  logic goodByte, take, popReq, held, above, runTimer, restart, hit, flush;
  logic pushes, empties;
  logic [TW-1:0] timer;
  logic [CW-1:0] nextCount;

  assign goodByte = byteValid && byteGood;
  assign take     = goodByte && !fifoFull;
  assign popReq   = rdEn && (wordCount != '0);
  assign held     = (wordCount != '0) || (packCnt != 2'd0);
  assign above    = wordCount > threshold;
  assign runTimer = held && !above && !toIrq;
  assign restart  = goodByte || popReq;
  assign hit      = runTimer && !restart && baudTick && (timer == TW'(TIMEOUT_TICKS - 1));
  assign flush    = hit && (packCnt != 2'd0) && !fifoFull;

  assign pushes   = (take && (packCnt == 2'd3)) || flush;
  assign empties  = popReq && (wordCount == CW'(1)) && !pushes;

  always_comb begin
    nextCount = wordCount;
    if (pushes && !popReq) nextCount = wordCount + CW'(1);
    else if (!pushes && popReq) nextCount = wordCount - CW'(1);
  end

  always_comb begin
    strobe.takeByte  = take;
    strobe.flushPart = flush;
    strobe.popWord   = popReq;
  end

  // idle timer in baud ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (restart || !runTimer) begin
      timer <= '0;
    end else if (baudTick) begin
      timer <= hit ? '0 : timer + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrIrq  <= 1'b0;
      toIrq   <= 1'b0;
      overrun <= 1'b0;
      lastLen <= 3'd4;
    end else begin
      thrIrq <= nextCount > threshold;
      if (hit) toIrq <= 1'b1;
      else if (empties) toIrq <= 1'b0;
      if (goodByte && fifoFull) overrun <= 1'b1;
      if (hit && packCnt == 2'd0) lastLen <= 3'd4;
      else if (flush) lastLen <= {1'b0, packCnt};
    end
  end

  // R4: level flag tracks the stored count
  p_thr_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    $stable(threshold) |-> (thrIrq == (wordCount > threshold)));

  // R5: idle flag only rises on a baud tick
  p_to_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toIrq) |-> $past(baudTick));

  // R5: nothing held means the timer rests at zero
  p_timer_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !held |=> (timer == '0));

  // R9: overrun is sticky
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R7: length indicator stays in range
  p_len_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastLen >= 3'd1) && (lastLen <= 3'd4));
endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer
  import rx_word_buffer_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TIMEOUT_TICKS = 64,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic [7:0]    byteData,
  input  logic          byteGood,
  input  logic          baudTick,
  input  logic [CW-1:0] threshold,
  input  logic          rdEn,
  output logic [31:0]   rdData,
  output logic [CW-1:0] wordCount,
  output logic          fifoEmpty,
  output logic [2:0]    lastLen,
  output logic          thrIrq,
  output logic          toIrq,
  output logic          overrun
);
  dpStrobe_t  strobe;
  logic [1:0] packCnt;
  logic       fifoFull;

  rx_word_ctrl #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .byteValid(byteValid), .byteGood(byteGood), .baudTick(baudTick),
    .threshold(threshold), .rdEn(rdEn),
    .wordCount(wordCount), .packCnt(packCnt), .fifoFull(fifoFull),
    .strobe(strobe), .thrIrq(thrIrq), .toIrq(toIrq),
    .overrun(overrun), .lastLen(lastLen)
  );

  rx_word_dp #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .CW(CW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(byteData),
    .rdData(rdData), .wordCount(wordCount), .packCnt(packCnt),
    .fifoFull(fifoFull)
  );

  assign fifoEmpty = (wordCount == '0);
endmodule

// File: tb/tb_rx_word_buffer.sv
module tb_rx_word_buffer;
  localparam int DEPTH = 4;
  localparam int TO = 6;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, byteGood = 1'b0, baudTick = 1'b0, rdEn = 1'b0;
  logic [7:0] byteData = '0;
  logic [CW-1:0] threshold = CW'(DEPTH - 1);
  logic [31:0] rdData;
  logic [CW-1:0] wordCount;
  logic fifoEmpty, thrIrq, toIrq, overrun;
  logic [2:0] lastLen;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  logic [31:0] acc = '0;
  int accN = 0;
  int seq = 0;

  always #5 clk = ~clk;

  rx_word_buffer #(.FIFO_DEPTH(DEPTH), .TIMEOUT_TICKS(TO)) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteGood(byteGood), .baudTick(baudTick), .threshold(threshold),
    .rdEn(rdEn), .rdData(rdData), .wordCount(wordCount), .fifoEmpty(fifoEmpty),
    .lastLen(lastLen), .thrIrq(thrIrq), .toIrq(toIrq), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nextVal();
    seq++;
    return 8'(seq * 37 + 5);
  endfunction

  task automatic sendByte(input logic [7:0] b, input bit good);
    @(negedge clk);
    byteValid = 1'b1; byteData = b; byteGood = good;
    @(negedge clk);
    byteValid = 1'b0; byteGood = 1'b0;
    if (good && expQ.size() < DEPTH) begin
      acc[8*accN +: 8] = b;
      accN++;
      if (accN == 4) begin expQ.push_back(acc); acc = '0; accN = 0; end
    end
  endtask

  task automatic sendGood(input int n);
    for (int i = 0; i < n; i++) sendByte(nextVal(), 1'b1);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baudTick = 1'b1;
      @(negedge clk); baudTick = 1'b0;
    end
  endtask

  task automatic popCheck(input string req);
    @(negedge clk);
    chk(rdData == expQ[0], req, rdData, expQ[0]);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    void'(expQ.pop_front());
  endtask

  task automatic drain();
    while (expQ.size() > 0) begin
      popCheck("R3 word order");
      chk(thrIrq == (expQ.size() > int'(threshold)), "R4 after read", thrIrq, expQ.size() > int'(threshold));
    end
    chk(fifoEmpty == 1'b1, "R3 empty after drain", fifoEmpty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(wordCount == 0, "R10 count", wordCount, 0);
    chk(fifoEmpty == 1'b1, "R10 empty", fifoEmpty, 1);
    chk(!thrIrq && !toIrq, "R10 irqs", {thrIrq, toIrq}, 0);
    chk(overrun == 1'b0, "R10 overrun", overrun, 0);
    chk(lastLen == 3'd4, "R10 lastLen", lastLen, 4);

    // R3: read of empty FIFO ignored
    @(negedge clk); rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    chk(wordCount == 0, "R3 empty read", wordCount, 0);

    // R1: bad characters interleaved with good ones
    threshold = CW'(DEPTH - 1);
    sendByte(8'hA1, 1'b1); sendByte(8'hEE, 1'b0); sendByte(8'hB2, 1'b1);
    sendByte(8'hDD, 1'b0); sendByte(8'hC3, 1'b1);
    chk(wordCount == 0, "R1 no early word", wordCount, 0);
    sendByte(8'hD4, 1'b1);
    chk(wordCount == 1, "R2 word after fourth good", wordCount, 1);
    chk(rdData == 32'hD4C3B2A1, "R1 R2 lane order", rdData, 32'hD4C3B2A1);
    for (int i = 0; i < 4; i++) sendByte(8'hF0, 1'b0);
    chk(wordCount == 1, "R1 bad bytes only", wordCount, 1);
    drain();

    // R4: threshold sweep over all fill levels
    for (int thr = 0; thr < DEPTH; thr++) begin
      threshold = CW'(thr);
      @(negedge clk);
      chk(thrIrq == 1'b0, "R4 empty", thrIrq, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        sendGood(4);
        chk(wordCount == CW'(k), "R2 count", wordCount, k);
        chk(thrIrq == (k > thr), "R4 level", thrIrq, k > thr);
      end
      drain();
    end

    // R5 R7 R8: expiry for every mix of full words and leftover characters
    threshold = CW'(DEPTH - 1);
    for (int w = 0; w <= 1; w++) begin
      for (int n = 0; n <= 3; n++) begin
        sendGood(4 * w + n);
        tick(TO - 1);
        chk(toIrq == 1'b0, "R5 not before limit", toIrq, 0);
        tick(1);
        if (w == 0 && n == 0) begin
          chk(toIrq == 1'b0, "R5 nothing held", toIrq, 0);
        end else begin
          chk(toIrq == 1'b1, "R5 expiry", toIrq, 1);
          if (accN > 0) begin expQ.push_back(acc); acc = '0; end
          chk(lastLen == ((n > 0) ? 3'(n) : 3'd4), "R7 lastLen", lastLen, (n > 0) ? n : 4);
          chk(wordCount == CW'(w + (n > 0)), "R7 flushed count", wordCount, w + (n > 0));
          accN = 0;
          drain();
          chk(toIrq == 1'b0, "R8 cleared by emptying", toIrq, 0);
        end
      end
    end

    // R6: restart by a character
    sendGood(1);
    tick(TO - 1);
    sendGood(1);
    tick(TO - 1);
    chk(toIrq == 1'b0, "R6 byte restart", toIrq, 0);
    tick(1);
    chk(toIrq == 1'b1, "R6 expiry after restart", toIrq, 1);
    expQ.push_back(acc); acc = '0; accN = 0;
    chk(lastLen == 3'd2, "R7 two bytes", lastLen, 2);
    drain();

    // R6: restart by a read
    sendGood(8);
    tick(TO - 1);
    popCheck("R6 read");
    tick(TO - 1);
    chk(toIrq == 1'b0, "R6 read restart", toIrq, 0);
    tick(1);
    chk(toIrq == 1'b1, "R6 expiry after read", toIrq, 1);
    chk(lastLen == 3'd4, "R7 no partial", lastLen, 4);
    drain();

    // R9: overrun
    chk(overrun == 1'b0, "R9 clear before", overrun, 0);
    sendGood(4 * DEPTH);
    chk(wordCount == CW'(DEPTH), "R9 full", wordCount, DEPTH);
    sendByte(8'h5A, 1'b1);
    chk(overrun == 1'b1, "R9 set", overrun, 1);
    chk(wordCount == CW'(DEPTH), "R9 count held", wordCount, DEPTH);
    drain();
    sendByte(8'h11, 1'b1); sendByte(8'h22, 1'b1); sendByte(8'h33, 1'b1); sendByte(8'h44, 1'b1);
    chk(rdData == 32'h44332211, "R9 discarded byte absent", rdData, 32'h44332211);
    drain();
    chk(overrun == 1'b1, "R9 sticky", overrun, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule